// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder/Subtractor

This block takes two 32-bit binary floating-point words and returns their sum or difference. Each word has a sign at bit 31, an 8-bit biased exponent at bits 30:23 (bias 127) and a 23-bit fraction at bits 22:0. Normal values have an unstored leading one. An exponent field of zero is read as zero whatever the fraction holds, so subnormal inputs are flushed. Inputs with an all-ones exponent are outside the operating range.

An operation is launched with a one-cycle `start` pulse while the block is idle. The block then steps through a short sequence: zero screening, ordering and alignment of the smaller operand, significand add or subtract, renormalization, and rounding to nearest with ties to even. Guard, round and sticky bits are carried below the significand. The result and two range flags are held on the outputs from the cycle `done` pulses until the next operation is launched.

Top module: `fp_addsub_seq`

## Requirements
- R1: For two normal operands with `sub_op`=0, `result` is the sum rounded to nearest (ties to even), with `ovf`=0 and `unf`=0 whenever the result is a normal number.
- R2: A `start` pulse seen while idle raises `busy` from the next cycle until `done` is high. `done` is high for exactly one cycle, after which `busy` is low.
- R3: With `sub_op`=1 the block returns `a_in` minus `b_in`, which is the same as adding `b_in` with its sign bit inverted.
- R4: Any operand whose exponent field is 0 counts as zero. If `a_in` is zero, the result is `b_in` with its sign inverted when `sub_op`=1. If only `b_in` is zero, the result is `a_in`. A zero returned this way has an all-zero magnitude.
- R5: The smaller operand is shifted right by the exponent difference. All bits shifted past the round position are ORed into a sticky bit, and that bit influences rounding even for differences above 24.
- R6: A carry out of the significand sum shifts the significand right by one and raises the exponent by one. The same happens when rounding carries out of the significand.
- R7: After a subtraction, leading zeros are removed by shifting left while the exponent is lowered. An exact cancellation returns +0 (0x00000000).
- R8: A discarded part that is exactly one half of an LSB rounds to the even neighbour: down when the kept LSB is 0, up when it is 1.
- R9: If the exponent would reach 255, after a carry or after rounding, the result is infinity with the result sign (exponent 255, fraction 0) and `ovf`=1.
- R10: If normalization would bring the exponent to 0 or below, the result is zero with the result sign and `unf`=1.
- R11: During reset `busy`, `done`, `ovf`, `unf` and `result` are all 0.
- R12: A `start` asserted while `busy` is high is ignored, and the running operation completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation when idle |
| sub_op | input | 1 | 0 = add, 1 = subtract (a minus b) |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | 32 | Rounded sum or difference |
| ovf | output | 1 | Exponent overflow, result is infinity |
| unf | output | 1 | Exponent underflow, result is zero |

## Verification
The assertions assume that no operand ever has an all-ones exponent. Under that assumption the internal magnitude ordering holds, and a normalized significand always reaches the rounding step with its top bit set. The stimulus uses only hand-picked words with exponents from 0 to 254. It places the near-maximum values where an overflow is wanted and the near-minimum ones where an underflow is wanted. The bench always waits for `done` before launching another operation, except in the one scenario that asserts `start` during a run on purpose to show it is ignored.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ZCHK  = 3'd1,
    ST_ALIGN = 3'd2,
    ST_ADD   = 3'd3,
    ST_NORM  = 3'd4,
    ST_ROUND = 3'd5,
    ST_FIN   = 3'd6
  } fpa_state_e;
endpackage

// File: rtl/fpa_rshift_sticky.sv
module fpa_rshift_sticky #(
  parameter int W  = 27,
  parameter int SW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0]  amt_c;
  logic [2*W-1:0] wide;

  // Distances at or beyond the width push every bit into the sticky half.
  always_comb begin
    if (amt >= SW'(W)) amt_c = CW'(W);
    else               amt_c = amt[CW-1:0];
    wide = {din, {W{1'b0}}} >> amt_c;
    dout = {wide[2*W-1:W+1], wide[W] | (|wide[W-1:0])};
  end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
  parameter int W  = 27,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);
  // The highest set bit is visited last in the loop, so its count is kept.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpa_rne.sv
module fpa_rne #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W+2:0] ext,
  output logic [SIG_W:0]   rounded
);
  logic keep_lsb, g_bit, r_bit, s_bit, bump;

  always_comb begin
    keep_lsb = ext[3];
    g_bit    = ext[2];
    r_bit    = ext[1];
    s_bit    = ext[0];
    bump     = g_bit & (r_bit | s_bit | keep_lsb);
    rounded  = {1'b0, ext[SIG_W+2:3]} + (SIG_W+1)'(bump);
  end
endmodule

// File: rtl/fp_addsub_seq.sv
module fp_addsub_seq #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      sub_op,
  input  logic [EXP_W+FRAC_W:0]     a_in,
  input  logic [EXP_W+FRAC_W:0]     b_in,
  output logic                      busy,
  output logic                      done,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      ovf,
  output logic                      unf
);
  import fpa_pkg::*;

  localparam int W      = EXP_W + FRAC_W + 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int EXT_W  = SIG_W + 3;
  localparam int SUM_W  = EXT_W + 1;
  localparam int EW     = EXP_W + 2;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam logic signed [EW-1:0] EXP_TOP = EW'((1 << EXP_W) - 1);

  fpa_state_e state_q, state_d;

  logic [W-1:0]            op_a_q, op_b_q;
  logic                    sub_q;
  logic                    cap_en;
  logic                    sign_q, sign_d;
  logic signed [EW-1:0]    exp_q, exp_d;
  logic [EXT_W-1:0]        big_q, big_d, small_q, small_d;
  logic [EXP_W-1:0]        diff_q, diff_d;
  logic                    effsub_q, effsub_d;
  logic [SUM_W-1:0]        sum_q, sum_d;
  logic [EXT_W-1:0]        norm_q, norm_d;
  logic [W-1:0]            res_q, res_d;
  logic                    ovf_q, ovf_d, unf_q, unf_d;
  logic                    res_en;

  // Field views of the captured operands.
  logic [EXP_W-1:0]  a_exp, b_exp;
  logic [FRAC_W-1:0] a_frac, b_frac;
  logic              a_zero, b_zero, a_sign, b_sign_eff, a_ge;

  assign a_exp      = op_a_q[W-2 -: EXP_W];
  assign b_exp      = op_b_q[W-2 -: EXP_W];
  assign a_frac     = op_a_q[FRAC_W-1:0];
  assign b_frac     = op_b_q[FRAC_W-1:0];
  assign a_zero     = (a_exp == '0);
  assign b_zero     = (b_exp == '0);
  assign a_sign     = op_a_q[W-1];
  assign b_sign_eff = op_b_q[W-1] ^ sub_q;
  assign a_ge       = (op_a_q[W-2:0] >= op_b_q[W-2:0]);

  // Datapath helpers.
  logic [EXT_W-1:0] aligned;
  logic [LZ_W-1:0]  lz_cnt;
  logic [SIG_W:0]   rounded;

  fpa_rshift_sticky #(.W(EXT_W), .SW(EXP_W)) u_align (
    .din  (small_q),
    .amt  (diff_q),
    .dout (aligned)
  );

  fpa_lzc #(.W(EXT_W), .CW(LZ_W)) u_lzc (
    .din   (sum_q[EXT_W-1:0]),
    .count (lz_cnt)
  );

  fpa_rne #(.SIG_W(SIG_W)) u_rne (
    .ext     (norm_q),
    .rounded (rounded)
  );

  logic signed [EW-1:0] e_inc, e_dec, e_rnd;
  logic [FRAC_W-1:0]    frac_rnd;

  // Next-state and datapath process.
  always_comb begin
    state_d  = state_q;
    cap_en   = 1'b0;
    sign_d   = sign_q;
    exp_d    = exp_q;
    big_d    = big_q;
    small_d  = small_q;
    diff_d   = diff_q;
    effsub_d = effsub_q;
    sum_d    = sum_q;
    norm_d   = norm_q;
    res_en   = 1'b0;
    res_d    = res_q;
    ovf_d    = 1'b0;
    unf_d    = 1'b0;
    e_inc    = exp_q + EW'(1);
    e_dec    = exp_q - $signed(EW'(lz_cnt));
    e_rnd    = rounded[SIG_W] ? e_inc : exp_q;
    frac_rnd = rounded[SIG_W] ? rounded[SIG_W-1:1] : rounded[FRAC_W-1:0];

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          state_d = ST_ZCHK;
        end
      end
      ST_ZCHK: begin
        if (a_zero) begin
          res_en  = 1'b1;
          res_d   = b_zero ? {b_sign_eff, {(W-1){1'b0}}}
                           : {b_sign_eff, op_b_q[W-2:0]};
          state_d = ST_FIN;
        end else if (b_zero) begin
          res_en  = 1'b1;
          res_d   = op_a_q;
          state_d = ST_FIN;
        end else begin
          effsub_d = a_sign ^ b_sign_eff;
          if (a_ge) begin
            sign_d  = a_sign;
            exp_d   = $signed({2'b00, a_exp});
            big_d   = {1'b1, a_frac, 3'b000};
            small_d = {1'b1, b_frac, 3'b000};
            diff_d  = a_exp - b_exp;
          end else begin
            sign_d  = b_sign_eff;
            exp_d   = $signed({2'b00, b_exp});
            big_d   = {1'b1, b_frac, 3'b000};
            small_d = {1'b1, a_frac, 3'b000};
            diff_d  = b_exp - a_exp;
          end
          state_d = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        small_d = aligned;
        state_d = ST_ADD;
      end
      ST_ADD: begin
        if (effsub_q) sum_d = {1'b0, big_q} - {1'b0, small_q};
        else          sum_d = {1'b0, big_q} + {1'b0, small_q};
        state_d = ST_NORM;
      end
      ST_NORM: begin
        if (sum_q == '0) begin
          res_en  = 1'b1;
          res_d   = '0;
          state_d = ST_FIN;
        end else if (sum_q[SUM_W-1]) begin
          if (e_inc >= EXP_TOP) begin
            res_en  = 1'b1;
            res_d   = {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            norm_d  = {sum_q[SUM_W-1:2], |sum_q[1:0]};
            exp_d   = e_inc;
            state_d = ST_ROUND;
          end
        end else if (e_dec <= 0) begin
          res_en  = 1'b1;
          res_d   = {sign_q, {(W-1){1'b0}}};
          unf_d   = 1'b1;
          state_d = ST_FIN;
        end else begin
          norm_d  = sum_q[EXT_W-1:0] << lz_cnt;
          exp_d   = e_dec;
          state_d = ST_ROUND;
        end
      end
      ST_ROUND: begin
        res_en = 1'b1;
        if (e_rnd >= EXP_TOP) begin
          res_d = {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf_d = 1'b1;
        end else begin
          res_d = {sign_q, e_rnd[EXP_W-1:0], frac_rnd};
        end
        state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_a_q   <= '0;
      op_b_q   <= '0;
      sub_q    <= 1'b0;
      sign_q   <= 1'b0;
      exp_q    <= '0;
      big_q    <= '0;
      small_q  <= '0;
      diff_q   <= '0;
      effsub_q <= 1'b0;
      sum_q    <= '0;
      norm_q   <= '0;
      res_q    <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      sign_q   <= sign_d;
      exp_q    <= exp_d;
      big_q    <= big_d;
      small_q  <= small_d;
      diff_q   <= diff_d;
      effsub_q <= effsub_d;
      sum_q    <= sum_d;
      norm_q   <= norm_d;
      if (cap_en) begin
        op_a_q <= a_in;
        op_b_q <= b_in;
        sub_q  <= sub_op;
        ovf_q  <= 1'b0;
        unf_q  <= 1'b0;
      end
      if (res_en) begin
        res_q <= res_d;
        ovf_q <= ovf_d;
        unf_q <= unf_d;
      end
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_FIN);
  assign result = res_q;
  assign ovf    = ovf_q;
  assign unf    = unf_q;

  // Assertions next to the logic they guard.
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_ops_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(op_a_q) && $stable(op_b_q) && $stable(sub_q)));

  p_norm_top_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROUND) |-> norm_q[EXT_W-1]);

  p_ovf_is_inf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  p_unf_is_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf) |-> (result[W-2:0] == '0));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  p_align_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADD) |-> (small_q <= big_q));
endmodule

// File: tb/fp_addsub_seq_bench.sv
module fp_addsub_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, sub_op;
  logic [31:0] a_in, b_in;
  logic        busy, done, ovf, unf;
  logic [31:0] result;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_addsub_seq u_fp_addsub_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .sub_op (sub_op),
    .a_in   (a_in),
    .b_in   (b_in),
    .busy   (busy),
    .done   (done),
    .result (result),
    .ovf    (ovf),
    .unf    (unf)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 40; n++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                        input logic [31:0] exp_r, input logic exp_o, input logic exp_u,
                        input string tag);
    bit seen;
    @(negedge clk);
    a_in = a; b_in = b; sub_op = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {tag, " R2 busy after start"}, {31'd0, busy}, 32'd1);
    wait_done(seen);
    check(seen, {tag, " R2 done seen"}, {31'd0, seen}, 32'd1);
    check(result === exp_r, {tag, " result"}, result, exp_r);
    check(ovf === exp_o, {tag, " R9 ovf"}, {31'd0, ovf}, {31'd0, exp_o});
    check(unf === exp_u, {tag, " R10 unf"}, {31'd0, unf}, {31'd0, exp_u});
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {tag, " R2 done one cycle"},
          {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_reset_r11;
    check(busy === 1'b0 && done === 1'b0, "R11 busy/done in reset", {30'd0, busy, done}, 32'd0);
    check(result === 32'd0 && ovf === 1'b0 && unf === 1'b0, "R11 result/flags in reset",
          result, 32'd0);
  endtask

  task automatic t_add_r1;
    run_op(32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 1'b0, 1'b0, "R1 1+2");
    run_op(32'h40200000, 32'hBF800000, 1'b0, 32'h3FC00000, 1'b0, 1'b0, "R1 2.5+-1");
    run_op(32'h3F400000, 32'h3E800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R1 0.75+0.25");
  endtask

  task automatic t_sub_r3;
    run_op(32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0, "R3 3-1");
    run_op(32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 1'b0, 1'b0, "R3 1-3");
    run_op(32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 1'b0, 1'b0, "R3 1-(-1)");
  endtask

  task automatic t_zero_r4;
    run_op(32'h00000000, 32'h3FC00000, 1'b0, 32'h3FC00000, 1'b0, 1'b0, "R4 0+1.5");
    run_op(32'h00000000, 32'h3FC00000, 1'b1, 32'hBFC00000, 1'b0, 1'b0, "R4 0-1.5");
    run_op(32'h3FC00000, 32'h00000000, 1'b1, 32'h3FC00000, 1'b0, 1'b0, "R4 1.5-0");
    run_op(32'h00000123, 32'h40000000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R4 subnormal a");
    run_op(32'h40000000, 32'h80000001, 1'b1, 32'h40000000, 1'b0, 1'b0, "R4 subnormal b");
    run_op(32'h00000000, 32'h00000055, 1'b1, 32'h80000000, 1'b0, 1'b0, "R4 both zero");
  endtask

  task automatic t_align_r5;
    run_op(32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R5 1+2^-30");
    run_op(32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 1'b0, 1'b0, "R5 1-2^-30");
    run_op(32'h3F800000, 32'h33820000, 1'b0, 32'h3F800001, 1'b0, 1'b0, "R5 sticky above half");
  endtask

  task automatic t_carry_r6;
    run_op(32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0, 1'b0, "R6 1.5+1.5");
    run_op(32'h3FFFFFFF, 32'h3FFFFFFF, 1'b0, 32'h407FFFFF, 1'b0, 1'b0, "R6 max-sig doubled");
    run_op(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R6 round carry");
  endtask

  task automatic t_cancel_r7;
    run_op(32'h3F800000, 32'h3F400000, 1'b1, 32'h3E800000, 1'b0, 1'b0, "R7 1-0.75");
    run_op(32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 1'b0, 1'b0, "R7 one ulp left");
    run_op(32'h3FC00000, 32'h3FC00000, 1'b1, 32'h00000000, 1'b0, 1'b0, "R7 x-x");
    run_op(32'hBFC00000, 32'hBFC00000, 1'b1, 32'h00000000, 1'b0, 1'b0, "R7 -x-(-x)");
  endtask

  task automatic t_tie_r8;
    run_op(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R8 tie even down");
    run_op(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, "R8 tie odd up");
  endtask

  task automatic t_ovf_r9;
    run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R9 max+max");
    run_op(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1, 1'b0, "R9 -max-max");
    run_op(32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R9 round to inf");
  endtask

  task automatic t_unf_r10;
    run_op(32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1, "R10 +tiny diff");
    run_op(32'h00800000, 32'h00C00000, 1'b1, 32'h80000000, 1'b0, 1'b1, "R10 -tiny diff");
  endtask

  task automatic t_busy_start_r12;
    bit seen;
    @(negedge clk);
    a_in = 32'h3F800000; b_in = 32'h40000000; sub_op = 1'b0; start = 1'b1;
    @(negedge clk);
    a_in = 32'h7F7FFFFF; b_in = 32'h7F7FFFFF; sub_op = 1'b1;
    wait_done(seen);
    start = 1'b0;
    check(seen, "R12 done seen", {31'd0, seen}, 32'd1);
    check(result === 32'h40400000, "R12 start ignored while busy", result, 32'h40400000);
    @(negedge clk);
    check(busy === 1'b0, "R12 idle after op", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; sub_op = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    t_reset_r11();
    rst_n = 1'b1;
    t_add_r1();
    t_sub_r3();
    t_zero_r4();
    t_align_r5();
    t_carry_r6();
    t_cancel_r7();
    t_tie_r8();
    t_ovf_r9();
    t_unf_r10();
    t_busy_start_r12();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule